// File: doc/BRIEF.md
# Shared Interrupt Status with Per-Host Enable Masks

This block collects interrupt events from eight pin sources and three counter sources and presents them to two independent bus masters. Every event pulse latches into a single raw status register that both masters see and may clear. Each master also owns a private enable mask, so it decides for itself which sources may raise its interrupt line. Neither master can disturb the other's mask.

A mask is never written as a whole. A master enables sources by writing ones to a set address and disables them by writing ones to a reset address; zero bits leave the mask alone. Software tasks sharing one master can therefore change their own bits without a read-modify-write. Reading either the set or the reset address returns the mask. Each master reads its own masked view (raw AND its mask) and gets one interrupt request, the OR of all its masked bits in both groups.

Each master has a simple register port: a write strobe, a three-bit address, write data and combinational read data. Pin events and counter events come in as one-cycle pulses, one bit per source.

Top module: `irq_dual_host`

## Requirements
- R1: After reset every raw bit and every mask bit is 0, every read returns 0 and both interrupt lines are low.
- R2: An event pulse on source i sets raw bit i at the next clock edge, and the bit stays set until software clears it.
- R3: A write to a raw address, from either master, clears each raw bit written as 1 and leaves each bit written as 0 unchanged. When both masters clear in the same cycle, the union of their bits is cleared.
- R4: When an event and a software clear hit the same raw bit in the same cycle, the bit ends up set.
- R5: A write to a master's set address enables each source written as 1 in that master's mask only; 0 bits have no effect.
- R6: A write to a master's reset address disables each source written as 1 in that master's mask only; 0 bits have no effect.
- R7: Reading the set address or the reset address returns the current mask of the reading master.
- R8: Reading a masked address returns raw AND the reading master's own mask, so the two masters can see different masked values for the same raw state.
- R9: A master's interrupt line is high exactly when its masked pin bits or its masked counter bits contain a 1. It follows the registered state in the same cycle, with no extra delay.
- R10: Address bit 2 selects the group (0 pin, 1 counter). Bits 1:0 select the function: 0 raw, 1 masked, 2 set, 3 reset. Source i maps to data bit i. Read bits above the group width are 0, and a write to a masked address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_evt_i | input | N_PIN | One-cycle event pulses from the pin sources |
| cnt_evt_i | input | N_CNT | One-cycle event pulses from the counter sources |
| host_we_i | input | N_HOST | Write strobe, one per master |
| host_addr_i | input | N_HOST x 3 | Register address, one per master |
| host_wdata_i | input | N_HOST x REG_W | Write data, one per master |
| host_rdata_o | output | N_HOST x REG_W | Read data for the addressed register, one per master |
| host_irq_o | output | N_HOST | Interrupt request, one per master |

## Verification
The bench builds the block with its default parameters: eight pin sources, three counter sources and two masters, so a register is eight bits wide. At this size every one of the 256 pin mask patterns can be set and then removed on one master while the other master's mask stays empty. The bench also walks every single source bit through event, ignored zero-write and clear from the opposite master. A long pseudo-random run with both masters writing at once then reaches the concurrent-clear and event-versus-clear collisions. After every cycle all eight addresses and both interrupt lines are compared against a model computed in the bench.

// File: rtl/irq_dual_pkg.sv
package irq_dual_pkg;

    localparam int ADDR_W = 3;
    localparam int GRP_BIT = 2;

    typedef enum logic [1:0] {
        FN_RAW    = 2'd0,
        FN_MASKED = 2'd1,
        FN_SET    = 2'd2,
        FN_RST    = 2'd3
    } reg_fn_e;

    localparam logic GRP_PIN = 1'b0;
    localparam logic GRP_CNT = 1'b1;

endpackage

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
    parameter int W      = 8,
    parameter int N_HOST = 2
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [W-1:0]                evt_i,
    input  logic [N_HOST-1:0][W-1:0]    clr_i,
    output logic [W-1:0]                raw_o
);

    typedef struct packed {
        logic [W-1:0] raw;
    } raw_state_t;

    raw_state_t st_d, st_q;
    logic [W-1:0] clr_any;

    always_comb begin
        clr_any = '0;
        for (int h = 0; h < N_HOST; h++) begin
            clr_any = clr_any | clr_i[h];
        end
        st_d = st_q;
        // hardware event applied after the clear so it wins a collision
        st_d.raw = (st_q.raw & ~clr_any) | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o = st_q.raw;

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] rst_i,
    output logic [W-1:0] mask_o
);

    typedef struct packed {
        logic [W-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.mask = (st_q.mask | set_i) & ~rst_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

endmodule

// File: rtl/irq_host_port.sv
module irq_host_port
    import irq_dual_pkg::*;
#(
    parameter int N_PIN = 8,
    parameter int N_CNT = 3,
    parameter int REG_W = 8
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [N_PIN-1:0]  pin_raw_i,
    input  logic [N_CNT-1:0]  cnt_raw_i,
    input  logic [N_PIN-1:0]  pin_mask_i,
    input  logic [N_CNT-1:0]  cnt_mask_i,
    output logic [N_PIN-1:0]  pin_clr_o,
    output logic [N_PIN-1:0]  pin_set_o,
    output logic [N_PIN-1:0]  pin_rst_o,
    output logic [N_CNT-1:0]  cnt_clr_o,
    output logic [N_CNT-1:0]  cnt_set_o,
    output logic [N_CNT-1:0]  cnt_rst_o,
    output logic [REG_W-1:0]  rdata_o,
    output logic              irq_o
);

    logic    grp;
    reg_fn_e fn;
    logic [N_PIN-1:0] pin_w;
    logic [N_CNT-1:0] cnt_w;

    assign grp   = addr_i[GRP_BIT];
    assign fn    = reg_fn_e'(addr_i[1:0]);
    assign pin_w = wdata_i[N_PIN-1:0];
    assign cnt_w = wdata_i[N_CNT-1:0];

    // write decode: the masked view is read-only
    always_comb begin
        pin_clr_o = '0;
        pin_set_o = '0;
        pin_rst_o = '0;
        cnt_clr_o = '0;
        cnt_set_o = '0;
        cnt_rst_o = '0;
        if (we_i) begin
            if (grp == GRP_PIN) begin
                case (fn)
                    FN_RAW:  pin_clr_o = pin_w;
                    FN_SET:  pin_set_o = pin_w;
                    FN_RST:  pin_rst_o = pin_w;
                    default: ;
                endcase
            end else begin
                case (fn)
                    FN_RAW:  cnt_clr_o = cnt_w;
                    FN_SET:  cnt_set_o = cnt_w;
                    FN_RST:  cnt_rst_o = cnt_w;
                    default: ;
                endcase
            end
        end
    end

    // read mux
    always_comb begin
        rdata_o = '0;
        if (grp == GRP_PIN) begin
            case (fn)
                FN_RAW:    rdata_o[N_PIN-1:0] = pin_raw_i;
                FN_MASKED: rdata_o[N_PIN-1:0] = pin_raw_i & pin_mask_i;
                default:   rdata_o[N_PIN-1:0] = pin_mask_i;
            endcase
        end else begin
            case (fn)
                FN_RAW:    rdata_o[N_CNT-1:0] = cnt_raw_i;
                FN_MASKED: rdata_o[N_CNT-1:0] = cnt_raw_i & cnt_mask_i;
                default:   rdata_o[N_CNT-1:0] = cnt_mask_i;
            endcase
        end
    end

    assign irq_o = (|(pin_raw_i & pin_mask_i)) | (|(cnt_raw_i & cnt_mask_i));

endmodule

// File: rtl/irq_dual_host.sv
module irq_dual_host
    import irq_dual_pkg::*;
#(
    parameter int N_PIN  = 8,
    parameter int N_CNT  = 3,
    parameter int N_HOST = 2,
    parameter int REG_W  = (N_PIN > N_CNT) ? N_PIN : N_CNT
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [N_PIN-1:0]                pin_evt_i,
    input  logic [N_CNT-1:0]                cnt_evt_i,
    input  logic [N_HOST-1:0]               host_we_i,
    input  logic [N_HOST-1:0][ADDR_W-1:0]   host_addr_i,
    input  logic [N_HOST-1:0][REG_W-1:0]    host_wdata_i,
    output logic [N_HOST-1:0][REG_W-1:0]    host_rdata_o,
    output logic [N_HOST-1:0]               host_irq_o
);

    logic [N_PIN-1:0]               pin_raw;
    logic [N_CNT-1:0]               cnt_raw;
    logic [N_HOST-1:0][N_PIN-1:0]   pin_mask;
    logic [N_HOST-1:0][N_CNT-1:0]   cnt_mask;
    logic [N_HOST-1:0][N_PIN-1:0]   pin_clr;
    logic [N_HOST-1:0][N_PIN-1:0]   pin_set;
    logic [N_HOST-1:0][N_PIN-1:0]   pin_rst;
    logic [N_HOST-1:0][N_CNT-1:0]   cnt_clr;
    logic [N_HOST-1:0][N_CNT-1:0]   cnt_set;
    logic [N_HOST-1:0][N_CNT-1:0]   cnt_rst;

    irq_raw_bank #(.W(N_PIN), .N_HOST(N_HOST)) u_pin_raw (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (pin_evt_i),
        .clr_i  (pin_clr),
        .raw_o  (pin_raw)
    );

    irq_raw_bank #(.W(N_CNT), .N_HOST(N_HOST)) u_cnt_raw (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (cnt_evt_i),
        .clr_i  (cnt_clr),
        .raw_o  (cnt_raw)
    );

    for (genvar h = 0; h < N_HOST; h++) begin : g_host
        irq_mask_bank #(.W(N_PIN)) u_pin_mask (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (pin_set[h]),
            .rst_i  (pin_rst[h]),
            .mask_o (pin_mask[h])
        );

        irq_mask_bank #(.W(N_CNT)) u_cnt_mask (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (cnt_set[h]),
            .rst_i  (cnt_rst[h]),
            .mask_o (cnt_mask[h])
        );

        irq_host_port #(.N_PIN(N_PIN), .N_CNT(N_CNT), .REG_W(REG_W)) u_port (
            .we_i       (host_we_i[h]),
            .addr_i     (host_addr_i[h]),
            .wdata_i    (host_wdata_i[h]),
            .pin_raw_i  (pin_raw),
            .cnt_raw_i  (cnt_raw),
            .pin_mask_i (pin_mask[h]),
            .cnt_mask_i (cnt_mask[h]),
            .pin_clr_o  (pin_clr[h]),
            .pin_set_o  (pin_set[h]),
            .pin_rst_o  (pin_rst[h]),
            .cnt_clr_o  (cnt_clr[h]),
            .cnt_set_o  (cnt_set[h]),
            .cnt_rst_o  (cnt_rst[h]),
            .rdata_o    (host_rdata_o[h]),
            .irq_o      (host_irq_o[h])
        );
    end

endmodule

// File: rtl/irq_dual_host_chk.sv
module irq_dual_host_chk
    import irq_dual_pkg::*;
#(
    parameter int N_PIN  = 8,
    parameter int N_CNT  = 3,
    parameter int N_HOST = 2,
    parameter int REG_W  = 8
) (
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic [N_PIN-1:0]                pin_evt_i,
    input logic [N_CNT-1:0]                cnt_evt_i,
    input logic [N_HOST-1:0]               host_we_i,
    input logic [N_HOST-1:0][ADDR_W-1:0]   host_addr_i,
    input logic [N_HOST-1:0][REG_W-1:0]    host_wdata_i,
    input logic [N_HOST-1:0]               host_irq_o,
    input logic [N_PIN-1:0]                pin_raw,
    input logic [N_CNT-1:0]                cnt_raw,
    input logic [N_HOST-1:0][N_PIN-1:0]    pin_mask,
    input logic [N_HOST-1:0][N_CNT-1:0]    cnt_mask
);

    // R4: a pin event is never lost to a clear in the same cycle
    a_r4_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|pin_evt_i) |=> ((pin_raw & $past(pin_evt_i)) == $past(pin_evt_i)));

    // R2: a counter event latches into the raw register
    a_r2_cnt_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|cnt_evt_i) |=> ((cnt_raw & $past(cnt_evt_i)) == $past(cnt_evt_i)));

    for (genvar h = 0; h < N_HOST; h++) begin : g_chk
        // R3: clear of pin raw bits without a competing event
        a_r3_raw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (host_we_i[h] && host_addr_i[h] == 3'd0 && pin_evt_i == '0)
            |=> ((pin_raw & $past(host_wdata_i[h][N_PIN-1:0])) == '0));

        // R5: ones written to the set address appear in this master's mask
        a_r5_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (host_we_i[h] && host_addr_i[h] == 3'd2)
            |=> ((pin_mask[h] & $past(host_wdata_i[h][N_PIN-1:0]))
                 == $past(host_wdata_i[h][N_PIN-1:0])));

        // R6: ones written to the reset address leave this master's mask
        a_r6_mask_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (host_we_i[h] && host_addr_i[h] == 3'd3)
            |=> ((pin_mask[h] & $past(host_wdata_i[h][N_PIN-1:0])) == '0));

        // R9: an empty mask keeps the line quiet
        a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pin_mask[h] == '0 && cnt_mask[h] == '0) |-> !host_irq_o[h]);
    end

endmodule

bind irq_dual_host irq_dual_host_chk #(
    .N_PIN(N_PIN), .N_CNT(N_CNT), .N_HOST(N_HOST), .REG_W(REG_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pin_evt_i    (pin_evt_i),
    .cnt_evt_i    (cnt_evt_i),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_irq_o   (host_irq_o),
    .pin_raw      (pin_raw),
    .cnt_raw      (cnt_raw),
    .pin_mask     (pin_mask),
    .cnt_mask     (cnt_mask)
);

// File: tb/test_irq_dual_host.sv
`timescale 1ns/100ps
module test_irq_dual_host;
    import irq_dual_pkg::*;

    localparam int NP = 8;
    localparam int NC = 3;
    localparam int NH = 2;
    localparam int RW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] pin_evt = '0;
    logic [NC-1:0] cnt_evt = '0;
    logic [NH-1:0] we = '0;
    logic [NH-1:0][ADDR_W-1:0] addr = '0;
    logic [NH-1:0][RW-1:0] wd = '0;
    logic [NH-1:0][RW-1:0] rd;
    logic [NH-1:0] irq;

    int checks = 0;
    int fails = 0;

    logic [NP-1:0] m_rp = '0;
    logic [NC-1:0] m_rc = '0;
    logic [NP-1:0] m_mp [NH];
    logic [NC-1:0] m_mc [NH];

    always #4 clk = ~clk;

    irq_dual_host i_irq_dual_host (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pin_evt_i    (pin_evt),
        .cnt_evt_i    (cnt_evt),
        .host_we_i    (we),
        .host_addr_i  (addr),
        .host_wdata_i (wd),
        .host_rdata_o (rd),
        .host_irq_o   (irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] exp_rd(int h, int a);
        logic [RW-1:0] v;
        v = '0;
        case (a)
            0: v = m_rp;
            1: v = m_rp & m_mp[h];
            2, 3: v = m_mp[h];
            4: v[NC-1:0] = m_rc;
            5: v[NC-1:0] = m_rc & m_mc[h];
            default: v[NC-1:0] = m_mc[h];
        endcase
        return v;
    endfunction

    function automatic string tag_of(int a);
        if (a == 0 || a == 4) return "R2";
        if (a == 1 || a == 5) return "R8";
        return "R7";
    endfunction

    task automatic rd_now(int h, logic [2:0] a, output logic [RW-1:0] v);
        addr[h] = a;
        #0.2;
        v = rd[h];
    endtask

    task automatic check_all();
        for (int h = 0; h < NH; h++) begin
            chk("R9", 32'(irq[h]), 32'((|(m_rp & m_mp[h])) | (|(m_rc & m_mc[h]))),
                $sformatf("irq host%0d", h));
        end
        for (int a = 0; a < 8; a++) begin
            addr[0] = 3'(a);
            addr[1] = 3'(a);
            #0.2;
            for (int h = 0; h < NH; h++) begin
                chk(tag_of(a), 32'(rd[h]), 32'(exp_rd(h, a)),
                    $sformatf("read host%0d addr%0d", h, a));
            end
        end
    endtask

    task automatic step(logic [NP-1:0] sp, logic [NC-1:0] sc,
                        logic w0, logic [2:0] a0, logic [RW-1:0] d0,
                        logic w1, logic [2:0] a1, logic [RW-1:0] d1);
        logic ww [NH];
        logic [2:0] aa [NH];
        logic [RW-1:0] dd [NH];
        logic [NP-1:0] clrp;
        logic [NC-1:0] clrc;
        ww[0] = w0; aa[0] = a0; dd[0] = d0;
        ww[1] = w1; aa[1] = a1; dd[1] = d1;
        pin_evt = sp;
        cnt_evt = sc;
        we = {w1, w0};
        addr[0] = a0;
        addr[1] = a1;
        wd[0] = d0;
        wd[1] = d1;
        @(posedge clk);
        clrp = '0;
        clrc = '0;
        for (int h = 0; h < NH; h++) begin
            if (ww[h]) begin
                case (aa[h])
                    3'd0: clrp = clrp | dd[h];
                    3'd2: m_mp[h] = m_mp[h] | dd[h];
                    3'd3: m_mp[h] = m_mp[h] & ~dd[h];
                    3'd4: clrc = clrc | dd[h][NC-1:0];
                    3'd6: m_mc[h] = m_mc[h] | dd[h][NC-1:0];
                    3'd7: m_mc[h] = m_mc[h] & ~dd[h][NC-1:0];
                    default: ;
                endcase
            end
        end
        m_rp = (m_rp & ~clrp) | sp;
        m_rc = (m_rc & ~clrc) | sc;
        @(negedge clk);
        pin_evt = '0;
        cnt_evt = '0;
        we = '0;
        wd = '0;
        check_all();
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [RW-1:0] v;
        logic [31:0] lf;
        for (int h = 0; h < NH; h++) begin
            m_mp[h] = '0;
            m_mc[h] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every address and both lines
        for (int a = 0; a < 8; a++) begin
            for (int h = 0; h < NH; h++) begin
                rd_now(h, 3'(a), v);
                chk("R1", 32'(v), 32'd0, $sformatf("reset read host%0d addr%0d", h, a));
            end
        end
        chk("R1", 32'(irq), 32'd0, "reset irq lines");

        // R2/R3: each pin source through event, zero write, clear by other master
        for (int i = 0; i < NP; i++) begin
            int h = i % 2;
            step(NP'(1) << i, '0, 1'b0, 3'd0, '0, 1'b0, 3'd0, '0);
            if (h == 0) step('0, '0, 1'b1, 3'd0, 8'h00, 1'b0, 3'd0, '0);
            else        step('0, '0, 1'b0, 3'd0, '0, 1'b1, 3'd0, 8'h00);
            rd_now(h, 3'd0, v);
            chk("R3", 32'(v[i]), 32'd1, "zero write keeps raw pin bit");
            if (h == 0) step('0, '0, 1'b0, 3'd0, '0, 1'b1, 3'd0, RW'(1) << i);
            else        step('0, '0, 1'b1, 3'd0, RW'(1) << i, 1'b0, 3'd0, '0);
            rd_now(h, 3'd0, v);
            chk("R3", 32'(v), 32'd0, "clear from other master");
        end
        for (int i = 0; i < NC; i++) begin
            step('0, NC'(1) << i, 1'b0, 3'd0, '0, 1'b0, 3'd0, '0);
            step('0, '0, 1'b1, 3'd4, 8'hF8, 1'b0, 3'd0, '0);
            rd_now(0, 3'd4, v);
            chk("R3", 32'(v), 32'(1 << i), "counter raw untouched by zero bits");
            step('0, '0, 1'b0, 3'd0, '0, 1'b1, 3'd4, RW'(1) << i);
            rd_now(1, 3'd4, v);
            chk("R3", 32'(v), 32'd0, "counter raw cleared");
        end

        // fill raw, then sweep every pin mask pattern on master 0
        step('1, '1, 1'b0, 3'd0, '0, 1'b0, 3'd0, '0);
        for (int m = 0; m < 256; m++) begin
            step('0, '0, 1'b1, 3'd2, RW'(m), 1'b0, 3'd0, '0);
            step('0, '0, 1'b1, 3'd3, RW'(m), 1'b0, 3'd0, '0);
        end
        for (int m = 0; m < 8; m++) begin
            step('0, '0, 1'b0, 3'd0, '0, 1'b1, 3'd6, RW'(m));
            step('0, '0, 1'b0, 3'd0, '0, 1'b1, 3'd7, RW'(m));
        end

        // R5 / R6: zero bits leave the mask alone
        step('0, '0, 1'b0, 3'd0, '0, 1'b1, 3'd2, 8'h0F);
        step('0, '0, 1'b0, 3'd0, '0, 1'b1, 3'd2, 8'h00);
        rd_now(1, 3'd2, v);
        chk("R5", 32'(v), 32'h0F, "set with zero data");
        rd_now(0, 3'd2, v);
        chk("R5", 32'(v), 32'h00, "other master mask untouched");
        step('0, '0, 1'b0, 3'd0, '0, 1'b1, 3'd3, 8'h00);
        rd_now(1, 3'd3, v);
        chk("R6", 32'(v), 32'h0F, "reset with zero data");
        step('0, '0, 1'b0, 3'd0, '0, 1'b1, 3'd3, 8'h03);
        rd_now(1, 3'd3, v);
        chk("R6", 32'(v), 32'h0C, "reset removes written bits");

        // R4: event and clear collide
        step(8'h04, 3'b010, 1'b1, 3'd0, 8'hFF, 1'b1, 3'd4, 8'hFF);
        rd_now(0, 3'd0, v);
        chk("R4", 32'(v), 32'h04, "pin event beats clear");
        rd_now(0, 3'd4, v);
        chk("R4", 32'(v), 32'h02, "counter event beats clear");

        // R10: writes to masked addresses are ignored
        step('0, '0, 1'b1, 3'd2, 8'hFF, 1'b1, 3'd6, 8'h07);
        step('0, '0, 1'b1, 3'd1, 8'hFF, 1'b1, 3'd5, 8'hFF);
        rd_now(0, 3'd2, v);
        chk("R10", 32'(v), 32'hFF, "masked write left mask");
        rd_now(0, 3'd0, v);
        chk("R10", 32'(v), 32'h04, "masked write left raw");
        rd_now(1, 3'd4, v);
        chk("R10", 32'(v), 32'h02, "counter read upper bits zero");

        // mixed traffic from both masters
        lf = 32'hACE1_2B3D;
        for (int n = 0; n < 2000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[7:0] & lf[15:8], lf[18:16] & lf[21:19],
                 lf[22], lf[25:23], lf[31:24],
                 lf[26], lf[29:27], lf[15:8] ^ lf[31:24]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule